// File: doc/BRIEF.md
# Sparse-Space Bus Address Translator

This block sits between a host port with a 40-bit byte address and a narrow 32-bit target bus. The host reaches target space through sparse windows. In a sparse window the target byte offset appears in the host address shifted left by five bit positions. The three low address bits are not used. Host address bits [4:3] give the transfer length. Host address bits [6:5] are the lowest two bits of the target offset, and they also give the byte lane. There are two windows, each with its own base: a memory window with a 27-bit offset and an I/O window with a 24-bit offset. A transaction that hits the memory window takes target address bits [31:29] from a three-bit extension register. Software loads that register through a separate write port.

Each accepted host request is checked for legality and then becomes one 32-bit target request, or two for a 64-bit access. The target request carries a longword-aligned address, four active-high byte enables, lane-shifted write data and an I/O-versus-memory flag. The request stays asserted until the target returns a one-cycle response. For a read, the block takes the addressed byte or halfword out of the returned word. For a 64-bit read, it joins the two longwords into one 64-bit result. A request that is not legal produces an error pulse and no target traffic. Only one host request is in flight at a time.

Top module: `sparse_xlate`

## Requirements
- R1: A host address from 0x02_0000_0000 up to (but not including) 0x03_0000_0000 selects the memory window; `tgt_io` is 0. A host address from 0x03_A000_0000 up to (but not including) 0x03_C000_0000 selects the I/O window; `tgt_io` is 1. The target offset is (host address − window base) >> 5. `tgt_we` follows `host_we`.
- R2: Host address bits [4:3] set the length: 00 = byte, 01 = 16-bit, 11 = 32-bit. `tgt_be` is 0001<<lane for a byte, 0011<<lane for 16-bit and 1111 for 32-bit, where bit k enables data bits [8k+7:8k].
- R3: The lane is host address bits [6:5]. Write data is placed in the lane: `host_wdata[7:0]` or `host_wdata[15:0]` is shifted left by 8×lane. A 32-bit write passes `host_wdata[31:0]` through unchanged.
- R4: In the memory window, `tgt_addr` = {ext[2:0], 2'b00, offset[26:2], 2'b00}. In the I/O window, the extension register is not applied and bits [31:24] are zero.
- R5: `tgt_addr[1:0]` is always 0 while `tgt_req` is high.
- R6: A byte read returns `(tgt_rdata >> 8×lane) & 0xFF` on `host_rdata`. A 16-bit read masks with 0xFFFF instead. A 32-bit read returns `tgt_rdata` unchanged. In every case `host_rdata` is zero-extended to 64 bits and valid in the cycle `host_done` is high.
- R7: When `host_dbl` is set, the access is 64 bits and must use length 11 at lane 0. It issues a first target request at the offset and a second at offset+4. The second offset wraps within the window's offset width. The write data is `host_wdata[31:0]` for the first and `host_wdata[63:32]` for the second. The read result is {second word, first word}.
- R8: The block raises `host_err` for one cycle, in the cycle after acceptance, and issues no target request, when any of these holds: the address is in neither window, the length is 10, a 16-bit access is at lane 1 or 3, a 32-bit access is at a nonzero lane, or `host_dbl` is set with a length other than 11.
- R9: A `csr_we` pulse loads `csr_wdata` into the extension register at that clock edge. A host request accepted at the same edge still uses the previous value.
- R10: `host_ready` is low from acceptance until the last target response of the request. `tgt_req` and its fields hold steady until `tgt_rsp`. `host_done` pulses in the cycle after the final `tgt_rsp`, and `host_ready` is high again in that cycle.
- R11: After reset, `host_ready` is 1, `tgt_req`, `host_err` and `host_done` are 0, and the extension register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Block can accept a host request |
| host_addr | input | 40 | Sparse host byte address |
| host_we | input | 1 | 1 = write, 0 = read |
| host_dbl | input | 1 | 64-bit access as two longwords |
| host_wdata | input | 64 | Host write data |
| host_done | output | 1 | One-cycle completion pulse |
| host_err | output | 1 | One-cycle illegal-request pulse |
| host_rdata | output | 64 | Aligned read result, valid with host_done |
| csr_we | input | 1 | Extension register write strobe |
| csr_wdata | input | 3 | Extension register write value |
| tgt_req | output | 1 | Target request pending |
| tgt_io | output | 1 | 1 = I/O space, 0 = memory space |
| tgt_we | output | 1 | Target write flag |
| tgt_addr | output | 32 | Longword-aligned target address |
| tgt_be | output | 4 | Active-high byte enables |
| tgt_wdata | output | 32 | Lane-placed write data |
| tgt_rsp | input | 1 | Target response pulse, completes the current request |
| tgt_rdata | input | 32 | Target read data, valid with tgt_rsp |

## Verification
An accepted request shows up one clock later, either as `tgt_req` with its fields or as a `host_err` pulse. A `tgt_rsp` ends the current request. One clock after it, either the second half of a 64-bit access is presented or `host_done` is raised with the read result. The bench applies the requirements to the host and target inputs it drives and keeps a behavioural per-clock model. It compares every output against that model on the falling edge, so each result is checked in exactly the cycle it is due. The target responder changes its latency between zero and two cycles, which exercises the hold-until-response rule and back-to-back half transfers.

// File: rtl/sparse_xlate_pkg.sv
package sparse_xlate_pkg;

  localparam int LW    = 32;
  localparam int LANES = LW / 8;
  localparam int SHIFT = 5;

  typedef enum logic [1:0] {
    LEN_BYTE = 2'b00,
    LEN_WORD = 2'b01,
    LEN_RSVD = 2'b10,
    LEN_LONG = 2'b11
  } len_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } phase_e;

  // byte-enable pattern for a length at a lane
  function automatic logic [LANES-1:0] lane_mask(input len_e len, input logic [1:0] lane);
    case (len)
      LEN_BYTE: return 4'b0001 << lane;
      LEN_WORD: return 4'b0011 << lane;
      LEN_LONG: return 4'b1111;
      default:  return 4'b0000;
    endcase
  endfunction

  // whether a length may start at a lane
  function automatic logic lane_legal(input len_e len, input logic [1:0] lane);
    case (len)
      LEN_BYTE: return 1'b1;
      LEN_WORD: return ~lane[0];
      LEN_LONG: return (lane == 2'b00);
      default:  return 1'b0;
    endcase
  endfunction

  // move narrow write data up into its lane
  function automatic logic [LW-1:0] lane_place(input len_e len, input logic [1:0] lane,
                                                input logic [LW-1:0] d);
    case (len)
      LEN_BYTE: return {24'b0, d[7:0]} << {lane, 3'b000};
      LEN_WORD: return {16'b0, d[15:0]} << {lane, 3'b000};
      default:  return d;
    endcase
  endfunction

  // pull narrow read data down from its lane
  function automatic logic [LW-1:0] lane_pick(input len_e len, input logic [1:0] lane,
                                               input logic [LW-1:0] w);
    logic [LW-1:0] s;
    s = w >> {lane, 3'b000};
    case (len)
      LEN_BYTE: return {24'b0, s[7:0]};
      LEN_WORD: return {16'b0, s[15:0]};
      default:  return w;
    endcase
  endfunction

endpackage

// File: rtl/sx_window_match.sv
module sx_window_match
  import sparse_xlate_pkg::*;
#(
  parameter int              HA_W    = 40,
  parameter int              TA_W    = 32,
  parameter int              OFS_W   = 27,
  parameter int              EXT_W   = 3,
  parameter bit              USE_EXT = 1'b1,
  parameter logic [HA_W-1:0] BASE    = '0
) (
  input  logic [HA_W-1:0]  host_addr,
  input  logic [EXT_W-1:0] ext,
  output logic             hit,
  output logic [TA_W-1:0]  addr_first,
  output logic [TA_W-1:0]  addr_second
);
  localparam int SPAN = OFS_W + SHIFT;
  localparam logic [HA_W-SPAN-1:0] TAG = BASE[HA_W-1:SPAN];

  logic [OFS_W-1:0] off_al;
  logic [OFS_W-1:0] off_nx;
  logic [EXT_W-1:0] ext_eff;
  logic [TA_W-1:0]  hi_part;
  logic             unused_low;

  assign unused_low  = ^host_addr[SHIFT+1:0];
  assign hit         = (host_addr[HA_W-1:SPAN] == TAG);
  assign off_al      = {host_addr[SPAN-1:SHIFT+2], 2'b00};
  assign off_nx      = off_al + OFS_W'(4);
  assign ext_eff     = USE_EXT ? ext : '0;
  assign hi_part     = {ext_eff, {(TA_W-EXT_W){1'b0}}};
  assign addr_first  = hi_part | TA_W'(off_al);
  assign addr_second = hi_part | TA_W'(off_nx);

endmodule

// File: rtl/sx_ext_reg.sv
module sx_ext_reg #(
  parameter int EXT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_we,
  input  logic [EXT_W-1:0] csr_wdata,
  output logic [EXT_W-1:0] ext
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ext <= '0;
    else if (csr_we) ext <= csr_wdata;
  end
endmodule

// File: rtl/sx_lane_fmt.sv
module sx_lane_fmt
  import sparse_xlate_pkg::*;
(
  input  len_e              len,
  input  logic [1:0]        lane,
  input  logic              dbl,
  input  logic              window_hit,
  input  logic [2*LW-1:0]   wdata,
  output logic              legal,
  output logic [LANES-1:0]  be,
  output logic [LW-1:0]     wdata_first,
  output logic [LW-1:0]     wdata_second
);
  assign legal        = window_hit && lane_legal(len, lane) && (!dbl || len == LEN_LONG);
  assign be           = lane_mask(len, lane);
  assign wdata_first  = dbl ? wdata[LW-1:0] : lane_place(len, lane, wdata[LW-1:0]);
  assign wdata_second = wdata[2*LW-1:LW];
endmodule

// File: rtl/sparse_xlate.sv
module sparse_xlate
  import sparse_xlate_pkg::*;
#(
  parameter int              HA_W      = 40,
  parameter int              EXT_W     = 3,
  parameter int              MEM_OFS_W = 27,
  parameter int              IO_OFS_W  = 24,
  parameter logic [HA_W-1:0] MEM_BASE  = 40'h02_0000_0000,
  parameter logic [HA_W-1:0] IO_BASE   = 40'h03_A000_0000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_valid,
  output logic             host_ready,
  input  logic [HA_W-1:0]  host_addr,
  input  logic             host_we,
  input  logic             host_dbl,
  input  logic [63:0]      host_wdata,
  output logic             host_done,
  output logic             host_err,
  output logic [63:0]      host_rdata,
  input  logic             csr_we,
  input  logic [EXT_W-1:0] csr_wdata,
  output logic             tgt_req,
  output logic             tgt_io,
  output logic             tgt_we,
  output logic [31:0]      tgt_addr,
  output logic [3:0]       tgt_be,
  output logic [31:0]      tgt_wdata,
  input  logic             tgt_rsp,
  input  logic [31:0]      tgt_rdata
);
  localparam int TA_W = LW;
  localparam int DW   = 2 * LW;

  phase_e            state;
  logic [EXT_W-1:0]  ext;
  len_e              len;
  logic [1:0]        lane;
  logic              unused_addr;
  logic              mem_hit, io_hit;
  logic [TA_W-1:0]   mem_a0, mem_a1, io_a0, io_a1;
  logic [TA_W-1:0]   sel_a0, sel_a1;
  logic              legal;
  logic [LANES-1:0]  be_new;
  logic [LW-1:0]     wd_first, wd_second;

  // held request context
  len_e              r_len;
  logic [1:0]        r_lane;
  logic              r_dbl;
  logic [TA_W-1:0]   r_addr_second;
  logic [LW-1:0]     r_wdata_second;
  logic [LW-1:0]     r_lo_word;

  // named internal events, used by the checker
  logic accept;
  logic reject;
  logic xfer_done;
  logic half_switch;

  assign unused_addr = ^host_addr[2:0];
  assign len         = len_e'(host_addr[4:3]);
  assign lane        = host_addr[6:5];

  sx_ext_reg #(.EXT_W(EXT_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_wdata(csr_wdata), .ext(ext)
  );

  sx_window_match #(
    .HA_W(HA_W), .TA_W(TA_W), .OFS_W(MEM_OFS_W), .EXT_W(EXT_W),
    .USE_EXT(1'b1), .BASE(MEM_BASE)
  ) u_mem_win (
    .host_addr(host_addr), .ext(ext), .hit(mem_hit),
    .addr_first(mem_a0), .addr_second(mem_a1)
  );

  sx_window_match #(
    .HA_W(HA_W), .TA_W(TA_W), .OFS_W(IO_OFS_W), .EXT_W(EXT_W),
    .USE_EXT(1'b0), .BASE(IO_BASE)
  ) u_io_win (
    .host_addr(host_addr), .ext(ext), .hit(io_hit),
    .addr_first(io_a0), .addr_second(io_a1)
  );

  assign sel_a0 = mem_hit ? mem_a0 : io_a0;
  assign sel_a1 = mem_hit ? mem_a1 : io_a1;

  sx_lane_fmt u_fmt (
    .len(len), .lane(lane), .dbl(host_dbl), .window_hit(mem_hit | io_hit),
    .wdata(host_wdata), .legal(legal), .be(be_new),
    .wdata_first(wd_first), .wdata_second(wd_second)
  );

  assign host_ready  = (state == ST_IDLE);
  assign tgt_req     = (state != ST_IDLE);
  assign accept      = host_valid && host_ready;
  assign reject      = accept && !legal;
  assign xfer_done   = tgt_req && tgt_rsp;
  assign half_switch = xfer_done && (state == ST_FIRST) && r_dbl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      host_done      <= 1'b0;
      host_err       <= 1'b0;
      host_rdata     <= '0;
      tgt_io         <= 1'b0;
      tgt_we         <= 1'b0;
      tgt_addr       <= '0;
      tgt_be         <= '0;
      tgt_wdata      <= '0;
      r_len          <= LEN_BYTE;
      r_lane         <= '0;
      r_dbl          <= 1'b0;
      r_addr_second  <= '0;
      r_wdata_second <= '0;
      r_lo_word      <= '0;
    end else begin
      host_done <= 1'b0;
      host_err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (reject) begin
            host_err <= 1'b1;
          end else if (accept) begin
            state          <= ST_FIRST;
            tgt_io         <= !mem_hit;
            tgt_we         <= host_we;
            tgt_addr       <= sel_a0;
            tgt_be         <= be_new;
            tgt_wdata      <= wd_first;
            r_len          <= len;
            r_lane         <= lane;
            r_dbl          <= host_dbl;
            r_addr_second  <= sel_a1;
            r_wdata_second <= wd_second;
          end
        end
        ST_FIRST: begin
          if (half_switch) begin
            state     <= ST_SECOND;
            r_lo_word <= tgt_rdata;
            tgt_addr  <= r_addr_second;
            tgt_wdata <= r_wdata_second;
          end else if (xfer_done) begin
            state      <= ST_IDLE;
            host_done  <= 1'b1;
            host_rdata <= tgt_we ? '0 : {{(DW-LW){1'b0}}, lane_pick(r_len, r_lane, tgt_rdata)};
          end
        end
        ST_SECOND: begin
          if (xfer_done) begin
            state      <= ST_IDLE;
            host_done  <= 1'b1;
            host_rdata <= tgt_we ? '0 : {tgt_rdata, r_lo_word};
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sparse_xlate_checks.sv
module sparse_xlate_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        host_ready,
  input logic        host_err,
  input logic        host_done,
  input logic        tgt_req,
  input logic        tgt_rsp,
  input logic        tgt_we,
  input logic [31:0] tgt_addr,
  input logic [3:0]  tgt_be,
  input logic [31:0] tgt_wdata,
  input logic        accept,
  input logic        half_switch
);

  // R10: busy target side blocks the host
  a_r10_busy_blocks_host: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req |-> !host_ready);

  // R10: request fields hold until the response
  a_r10_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_req && !tgt_rsp) |=> (tgt_req && $stable(tgt_addr) && $stable(tgt_be)
                                && $stable(tgt_we) && $stable(tgt_wdata)));

  // R10: completion only follows a target response
  a_r10_done_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |-> $past(tgt_req && tgt_rsp));

  // R5: issued address is longword aligned
  a_r5_addr_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req |-> (tgt_addr[1:0] == 2'b00));

  // R2: byte enables take only legal shapes
  a_r2_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req |-> (tgt_be inside {4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                4'b0011, 4'b1100, 4'b1111}));

  // R8: an error pulse follows an acceptance and carries no request
  a_r8_err_no_xact: assert property (@(posedge clk) disable iff (!rst_n)
    host_err |-> (!tgt_req && $past(accept)));

  // R7: the second half of a 64-bit access is a full longword still pending
  a_r7_second_half: assert property (@(posedge clk) disable iff (!rst_n)
    half_switch |=> (tgt_req && tgt_be == 4'b1111 && !host_ready));

endmodule

bind sparse_xlate sparse_xlate_checks u_checks (
  .clk(clk), .rst_n(rst_n), .host_ready(host_ready), .host_err(host_err),
  .host_done(host_done), .tgt_req(tgt_req), .tgt_rsp(tgt_rsp), .tgt_we(tgt_we),
  .tgt_addr(tgt_addr), .tgt_be(tgt_be), .tgt_wdata(tgt_wdata),
  .accept(accept), .half_switch(half_switch)
);

// File: tb/sparse_xlate_tb.sv
`timescale 1ns/1ps
module sparse_xlate_tb_top;

  localparam logic [39:0] MEMB = 40'h02_0000_0000;
  localparam logic [39:0] IOB  = 40'h03_A000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0;
  logic        host_ready;
  logic [39:0] host_addr = '0;
  logic        host_we = 1'b0;
  logic        host_dbl = 1'b0;
  logic [63:0] host_wdata = '0;
  logic        host_done, host_err;
  logic [63:0] host_rdata;
  logic        csr_we = 1'b0;
  logic [2:0]  csr_wdata = '0;
  logic        tgt_req, tgt_io, tgt_we;
  logic [31:0] tgt_addr;
  logic [3:0]  tgt_be;
  logic [31:0] tgt_wdata;
  logic        tgt_rsp = 1'b0;
  logic [31:0] tgt_rdata = '0;

  always #10 clk = ~clk;

  sparse_xlate dut_i (
    .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
    .host_addr(host_addr), .host_we(host_we), .host_dbl(host_dbl),
    .host_wdata(host_wdata), .host_done(host_done), .host_err(host_err),
    .host_rdata(host_rdata), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .tgt_req(tgt_req), .tgt_io(tgt_io), .tgt_we(tgt_we), .tgt_addr(tgt_addr),
    .tgt_be(tgt_be), .tgt_wdata(tgt_wdata), .tgt_rsp(tgt_rsp), .tgt_rdata(tgt_rdata)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    cmp_en = 1'b0;
  string phase = "R11";

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // target data the responder returns for an address
  function automatic logic [31:0] resp_f(input logic [31:0] a);
    return (a * 32'h0019_660D) + 32'h3C6E_F35F;
  endfunction

  // requirement-level decode of one host request
  task automatic ref_decode(input logic [39:0] a, input bit dbl, input logic [63:0] wd,
                            input logic [2:0] ext, output bit ok, output bit io,
                            output logic [31:0] a0, output logic [31:0] a1,
                            output logic [3:0] be, output logic [31:0] w0,
                            output logic [31:0] w1, output int size, output int lane);
    longint unsigned ua, rel, off, base, span;
    int ob, lc;
    ok = 1; io = 0; a0 = 0; a1 = 0; be = 0; w0 = 0; w1 = 0; size = 0; lane = 0;
    ua = {24'd0, a};
    rel = 0; ob = 27;
    if (ua >= {24'd0, MEMB} && ua < {24'd0, MEMB} + 64'h1_0000_0000) begin
      rel = ua - {24'd0, MEMB}; ob = 27;
    end else if (ua >= {24'd0, IOB} && ua < {24'd0, IOB} + 64'h2000_0000) begin
      io = 1; rel = ua - {24'd0, IOB}; ob = 24;
    end else begin
      ok = 0;
      return;
    end
    off  = rel / 32;
    lc   = int'((rel / 8) % 4);
    lane = int'(off % 4);
    size = (lc == 0) ? 1 : (lc == 1) ? 2 : (lc == 3) ? 4 : 0;
    if (size == 0) ok = 0;
    else if ((lane % size) != 0) ok = 0;
    if (dbl && size != 4) ok = 0;
    if (!ok) return;
    base = off - (off % 4);
    span = 64'd1 << ob;
    a0 = 32'(base);
    a1 = 32'((base + 4) % span);
    if (!io) begin
      a0 = a0 | (32'(ext) << 29);
      a1 = a1 | (32'(ext) << 29);
    end
    be = 4'(((1 << size) - 1) << lane);
    if (dbl) w0 = wd[31:0];
    else     w0 = 32'((wd & ((64'd1 << (8 * size)) - 1)) << (8 * lane));
    w1 = wd[63:32];
  endtask

  // behavioural per-clock model
  bit          m_ready, m_req, m_err, m_done, m_io, m_we, m_dbl, m_second;
  logic [31:0] m_addr, m_addr1, m_wdata, m_wdata1, m_lo;
  logic [3:0]  m_be;
  logic [63:0] m_rdata;
  logic [2:0]  m_ext;
  int          m_size, m_lane;
  bit          d_ok, d_io;
  logic [31:0] d_a0, d_a1, d_w0, d_w1, d_word, d_mask;
  logic [3:0]  d_be;
  int          d_size, d_lane;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ready <= 1; m_req <= 0; m_err <= 0; m_done <= 0; m_io <= 0; m_we <= 0;
      m_dbl <= 0; m_second <= 0; m_addr <= 0; m_addr1 <= 0; m_wdata <= 0;
      m_wdata1 <= 0; m_lo <= 0; m_be <= 0; m_rdata <= 0; m_ext <= 0;
      m_size <= 1; m_lane <= 0;
    end else begin
      m_err  <= 0;
      m_done <= 0;
      if (csr_we) m_ext <= csr_wdata;
      if (m_ready) begin
        if (host_valid) begin
          ref_decode(host_addr, host_dbl, host_wdata, m_ext, d_ok, d_io, d_a0, d_a1,
                     d_be, d_w0, d_w1, d_size, d_lane);
          if (!d_ok) m_err <= 1;
          else begin
            m_ready <= 0; m_req <= 1; m_io <= d_io; m_we <= host_we; m_dbl <= host_dbl;
            m_second <= 0; m_addr <= d_a0; m_addr1 <= d_a1; m_be <= d_be;
            m_wdata <= d_w0; m_wdata1 <= d_w1; m_size <= d_size; m_lane <= d_lane;
          end
        end
      end else if (tgt_rsp) begin
        d_word = resp_f(m_addr);
        if (m_dbl && !m_second) begin
          m_second <= 1; m_lo <= d_word; m_addr <= m_addr1; m_wdata <= m_wdata1;
        end else begin
          m_ready <= 1; m_req <= 0; m_done <= 1;
          d_mask = (m_size == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * m_size)) - 1);
          if (m_dbl) m_rdata <= {d_word, m_lo};
          else       m_rdata <= {32'd0, (d_word >> (8 * m_lane)) & d_mask};
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      cmp({phase, " R10 host_ready"}, 64'(host_ready), 64'(m_ready));
      cmp({phase, " R10 tgt_req"},    64'(tgt_req),    64'(m_req));
      cmp({phase, " R8 host_err"},    64'(host_err),   64'(m_err));
      cmp({phase, " R10 host_done"},  64'(host_done),  64'(m_done));
      if (m_req && tgt_req) begin
        cmp({phase, " R1 R5 tgt_addr"}, 64'(tgt_addr), 64'(m_addr));
        cmp({phase, " R2 tgt_be"},      64'(tgt_be),   64'(m_be));
        cmp({phase, " R1 tgt_io"},      64'(tgt_io),   64'(m_io));
        cmp({phase, " R1 tgt_we"},      64'(tgt_we),   64'(m_we));
        if (m_we) cmp({phase, " R3 tgt_wdata"}, 64'(tgt_wdata), 64'(m_wdata));
      end
      if (m_done && host_done && !m_we)
        cmp({phase, " R6 host_rdata"}, host_rdata, m_rdata);
    end
  end

  // target responder with a latency of 0..2 cycles
  int lat = 0;
  int lat_seq = 1;
  always @(negedge clk) begin
    tgt_rsp = 1'b0;
    if (rst_n && tgt_req) begin
      if (lat == 0) begin
        tgt_rsp   = 1'b1;
        tgt_rdata = resp_f(tgt_addr);
        lat       = lat_seq;
        lat_seq   = (lat_seq + 1) % 3;
      end else begin
        lat--;
      end
    end
  end

  function automatic logic [39:0] sp(input logic [39:0] base, input int unsigned off,
                                     input int lc);
    return base + (40'(off) << 5) + (40'(lc) << 3);
  endfunction

  task automatic op(input logic [39:0] a, input bit we, input bit dbl, input logic [63:0] wd);
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_valid = 1; host_addr = a; host_we = we; host_dbl = dbl; host_wdata = wd;
    @(negedge clk);
    host_valid = 0;
  endtask

  task automatic csr_write(input logic [2:0] v);
    @(negedge clk);
    csr_we = 1; csr_wdata = v;
    @(negedge clk);
    csr_we = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    phase = "R11";
    repeat (3) @(negedge clk);
    cmp("R11 reset host_ready", 64'(host_ready), 64'd1);
    cmp("R11 reset tgt_req",    64'(tgt_req),    64'd0);
    cmp("R11 reset host_err",   64'(host_err),   64'd0);
    cmp("R11 reset host_done",  64'(host_done),  64'd0);
    rst_n  = 1;
    cmp_en = 1;
    // extension register still zero after reset
    op(sp(MEMB, 32'h0123_4565, 0), 0, 0, 0);
    op(sp(MEMB, 32'h0000_0100, 3), 1, 0, 64'hDEAD_BEEF);

    phase = "R4";
    csr_write(3'b101);
    op(sp(MEMB, 32'h07FF_FFF1, 0), 1, 0, 64'h0000_00A7);
    op(sp(MEMB, 32'h0456_7890, 3), 0, 0, 0);
    csr_write(3'b010);
    op(sp(MEMB, 32'h0000_0042, 1), 0, 0, 0);

    phase = "R2 R3";
    for (int l = 0; l < 4; l++) op(sp(MEMB, 32'h0001_0000 + l, 0), 1, 0, 64'h1111_2200 + l);
    for (int l = 0; l < 4; l += 2) op(sp(MEMB, 32'h0002_0000 + l, 1), 1, 0, 64'hFFFF_5AC3 + l);
    op(sp(MEMB, 32'h0003_0000, 3), 1, 0, 64'h8765_4321_CAFE_F00D);

    phase = "R6";
    for (int l = 0; l < 4; l++) op(sp(MEMB, 32'h0004_0010 + l, 0), 0, 0, 0);
    for (int l = 0; l < 4; l += 2) op(sp(MEMB, 32'h0004_0020 + l, 1), 0, 0, 0);
    op(sp(MEMB, 32'h0004_0030, 3), 0, 0, 0);

    phase = "R1 R4";
    op(sp(IOB, 32'h0000_03F8, 0), 1, 0, 64'h55);
    op(sp(IOB, 32'h0000_03FB, 0), 0, 0, 0);
    op(sp(IOB, 32'h00FF_FFFE, 1), 0, 0, 0);
    op(sp(IOB, 32'h0012_3450, 3), 1, 0, 64'h0BAD_F00D);

    phase = "R8";
    op(sp(MEMB, 32'h0000_0201, 1), 0, 0, 0);
    op(sp(MEMB, 32'h0000_0203, 1), 1, 0, 0);
    op(sp(MEMB, 32'h0000_0202, 3), 0, 0, 0);
    op(sp(IOB,  32'h0000_0200, 2), 0, 0, 0);
    op(40'h01_0000_0000, 0, 0, 0);
    op(40'h03_9000_0018, 0, 0, 0);
    op(40'h03_C000_0018, 1, 0, 0);
    op(sp(MEMB, 32'h0000_0200, 0), 0, 1, 0);
    op(sp(MEMB, 32'h0000_0200, 1), 1, 1, 0);
    op(sp(MEMB, 32'h0000_0204, 3), 0, 0, 0);

    phase = "R7";
    op(sp(MEMB, 32'h0005_0000, 3), 0, 1, 0);
    op(sp(MEMB, 32'h0005_0100, 3), 1, 1, 64'h0102_0304_A0B0_C0D0);
    op(sp(IOB,  32'h0000_1000, 3), 0, 1, 0);
    op(sp(MEMB, 32'h07FF_FFFC, 3), 0, 1, 0);

    phase = "R9";
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    csr_we = 1; csr_wdata = 3'b111;
    host_valid = 1; host_addr = sp(MEMB, 32'h0000_0500, 3); host_we = 0; host_dbl = 0;
    @(negedge clk);
    csr_we = 0; host_valid = 0;
    op(sp(MEMB, 32'h0000_0504, 3), 0, 0, 0);

    phase = "R10";
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_valid = 1; host_addr = sp(MEMB, 32'h0000_0700, 3); host_we = 0; host_dbl = 0;
    repeat (25) @(negedge clk);
    host_addr = sp(MEMB, 32'h0000_0710, 3); host_dbl = 1;
    repeat (25) @(negedge clk);
    host_valid = 0;

    repeat (12) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule